// File: doc/BRIEF.md
# Serial Transmitter with Counted Break and Idle Gap

This block serialises bytes that it pulls one at a time from an upstream FIFO read port. Each byte goes out as a frame: a low start bit, eight data bits with the least significant bit first, an optional parity bit and one or two high stop bits. Every bit lasts one bit period. A bit period is the interval between two pulses on the `baud_tick` input, which a separate rate generator supplies. After the stop bits the line stays high for a programmable number of bit periods before the next frame may start.

When the FIFO is found empty at the end of a frame's gap, the block raises a one-cycle transmit-done pulse. If a break is requested and its length is non-zero, it then drives the line low for that many bit periods and raises a break-done pulse. The line then returns high for the idle gap length, with a floor of one bit period, and a break-idle-done pulse marks the end of that recovery interval. The sequencer state is exposed as a 4-bit code. The serial output can be delayed by 0 to 15 clock cycles to line up with external circuitry.

The block assumes that configuration inputs stay stable while a transfer is in progress and that `baud_tick` is a single-cycle pulse.

Top module: `serial_brk_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets: `txd` is 1, `tx_state` is 0 (idle), and `fifo_rd`, `tx_done`, `brk_done` and `brk_idle_done` are all 0.
- R2: A frame starts with a low start bit (state 1). Eight data bits follow, least significant first, in states 2 to 9. Then comes a high first stop bit (state 11). Each bit occupies exactly one bit period.
- R3: With `cfg_parity_en` set, a parity bit (state 10) follows data bit 7. Its value is the XOR of the eight data bits when `cfg_parity_odd` is 0, and the inverse of that XOR when `cfg_parity_odd` is 1. With `cfg_parity_en` clear, there is no parity period.
- R4: With `cfg_two_stop` set, a second high stop bit (state 12) follows the first.
- R5: After the stop bits, the line stays high for `cfg_idle_bits` bit periods (state 14) before the block samples the FIFO again. A value of 0 lets frames run back to back.
- R6: `fifo_rd` pulses for one cycle, only while `fifo_empty` is 0. It pulses exactly once per byte sent, in the tick cycle that begins the byte's start bit. `fifo_rdata` is captured in that same cycle.
- R7: `tx_done` pulses once when a frame's gap ends with the FIFO empty, except at the end of a post-break recovery interval.
- R8: With `cfg_brk_en` set and `cfg_brk_bits` equal to N>0, the line is held low for N bit periods (state 13) after `tx_done`, then `brk_done` pulses. If N is 0 or `cfg_brk_en` is clear, no break is sent and `brk_done` stays 0.
- R9: After a break, the line stays high (state 14) for max(`cfg_idle_bits`,1) bit periods. `brk_idle_done` then pulses once and the block returns to idle.
- R10: `tx_state` changes only in cycles that follow a `baud_tick` pulse.
- R11: `txd` follows the internal line level delayed by `cfg_txd_delay` clock cycles (0 to 15).
- R12: At most one of `tx_done`, `brk_done` and `brk_idle_done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit-period boundary |
| fifo_empty | input | 1 | Upstream FIFO holds no byte |
| fifo_rdata | input | 8 | Byte at the FIFO head |
| fifo_rd | output | 1 | Pop strobe for the FIFO head |
| cfg_parity_en | input | 1 | Insert a parity bit |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_two_stop | input | 1 | Send two stop bits |
| cfg_idle_bits | input | 10 | Idle gap length in bit periods |
| cfg_brk_en | input | 1 | Send a break once the FIFO drains |
| cfg_brk_bits | input | 8 | Break length in bit periods |
| cfg_txd_delay | input | 4 | Output delay in clock cycles |
| txd | output | 1 | Serial output, high when idle |
| tx_state | output | 4 | Sequencer state code |
| tx_done | output | 1 | FIFO drained pulse |
| brk_done | output | 1 | Break finished pulse |
| brk_idle_done | output | 1 | Post-break recovery finished pulse |

## Verification
Several properties are checked on every clock cycle. Pops occur only from a non-empty FIFO, and every entry into the start state is preceded by a pop. The state holds between ticks. The three completion pulses never overlap. A transmit-done pulse follows only an empty FIFO, and a break-done pulse follows only the break state. Only the bench scenarios can show the line levels bit by bit: data order, the parity value for each polarity, the gap and break lengths, the exact bit period in which each pulse fires, and the clock-cycle offset added by the output delay.

// File: rtl/txb_pkg.sv
// Shared definitions for the break-capable serial transmitter.
// Assumes exactly eight data bits per frame; the state encoding depends on it.
package txb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_START = 4'd1,
        ST_D0    = 4'd2,
        ST_D1    = 4'd3,
        ST_D2    = 4'd4,
        ST_D3    = 4'd5,
        ST_D4    = 4'd6,
        ST_D5    = 4'd7,
        ST_D6    = 4'd8,
        ST_D7    = 4'd9,
        ST_PAR   = 4'd10,
        ST_STOP1 = 4'd11,
        ST_STOP2 = 4'd12,
        ST_BRK   = 4'd13,
        ST_GAP   = 4'd14
    } txb_state_e;

    localparam int TXB_DATA_BITS = 8;

endpackage

// File: rtl/txb_sequencer.sv
// Frame sequencer: walks start, data, parity, stop, gap and break periods.
// It advances only on baud_tick, pops the FIFO when it starts a byte, and
// issues registered completion pulses.
// Assumes the configuration inputs are stable during a transfer.
module txb_sequencer
    import txb_pkg::*;
#(
    parameter int IDLE_W = 10,
    parameter int BRK_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     baud_tick,
    input  logic                     fifo_empty,
    input  logic [TXB_DATA_BITS-1:0] fifo_rdata,
    input  logic                     cfg_parity_en,
    input  logic                     cfg_two_stop,
    input  logic [IDLE_W-1:0]        cfg_idle_bits,
    input  logic                     cfg_brk_en,
    input  logic [BRK_W-1:0]         cfg_brk_bits,
    output txb_state_e               state_o,
    output logic [TXB_DATA_BITS-1:0] data_o,
    output logic                     fifo_rd_o,
    output logic                     done_o,
    output logic                     brk_done_o,
    output logic                     brk_idle_done_o
);

    localparam int CNT_W = (IDLE_W > BRK_W) ? IDLE_W : BRK_W;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    txb_state_e               state_q, state_d;
    logic [TXB_DATA_BITS-1:0] data_q, data_d;
    logic [CNT_W-1:0]         cnt_q, cnt_d;
    logic                     after_brk_q, after_brk_d;
    logic                     done_q, brk_done_q, brk_idle_q;
    logic                     done_d, brk_done_d, brk_idle_d;
    logic                     pop;
    logic                     go_post, go_decide;
    logic [CNT_W-1:0]         idle_len, brk_len, rec_len;

    assign idle_len = CNT_W'(cfg_idle_bits);
    assign brk_len  = CNT_W'(cfg_brk_bits);
    assign rec_len  = (cfg_idle_bits == '0) ? CNT_ONE : idle_len;

    // Next-state, counter and pulse decisions, taken only on a bit boundary.
    always_comb begin
        state_d     = state_q;
        data_d      = data_q;
        cnt_d       = cnt_q;
        after_brk_d = after_brk_q;
        pop         = 1'b0;
        done_d      = 1'b0;
        brk_done_d  = 1'b0;
        brk_idle_d  = 1'b0;
        go_post     = 1'b0;
        go_decide   = 1'b0;
        if (baud_tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!fifo_empty) begin
                        pop     = 1'b1;
                        data_d  = fifo_rdata;
                        state_d = ST_START;
                    end
                end
                ST_START: state_d = ST_D0;
                ST_D7:    state_d = cfg_parity_en ? ST_PAR : ST_STOP1;
                ST_PAR:   state_d = ST_STOP1;
                ST_STOP1: begin
                    if (cfg_two_stop) state_d = ST_STOP2;
                    else              go_post = 1'b1;
                end
                ST_STOP2: go_post = 1'b1;
                ST_GAP: begin
                    if (cnt_q <= CNT_ONE) go_decide = 1'b1;
                    else                  cnt_d = cnt_q - CNT_ONE;
                end
                ST_BRK: begin
                    if (cnt_q <= CNT_ONE) begin
                        brk_done_d  = 1'b1;
                        after_brk_d = 1'b1;
                        state_d     = ST_GAP;
                        cnt_d       = rec_len;
                    end else begin
                        cnt_d = cnt_q - CNT_ONE;
                    end
                end
                default: state_d = txb_state_e'(4'(state_q + 4'd1));
            endcase
        end
        if (go_post) begin
            if (cfg_idle_bits != '0) begin
                state_d = ST_GAP;
                cnt_d   = idle_len;
            end else begin
                go_decide = 1'b1;
            end
        end
        if (go_decide) begin
            brk_idle_d  = after_brk_q;
            after_brk_d = 1'b0;
            if (!fifo_empty) begin
                pop     = 1'b1;
                data_d  = fifo_rdata;
                state_d = ST_START;
            end else if (after_brk_q) begin
                state_d = ST_IDLE;
            end else begin
                done_d = 1'b1;
                if (cfg_brk_en && (cfg_brk_bits != '0)) begin
                    state_d = ST_BRK;
                    cnt_d   = brk_len;
                end else begin
                    state_d = ST_IDLE;
                end
            end
        end
    end

    // Register the sequencer state, the captured byte and the pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            data_q      <= '0;
            cnt_q       <= '0;
            after_brk_q <= 1'b0;
            done_q      <= 1'b0;
            brk_done_q  <= 1'b0;
            brk_idle_q  <= 1'b0;
        end else begin
            state_q     <= state_d;
            data_q      <= data_d;
            cnt_q       <= cnt_d;
            after_brk_q <= after_brk_d;
            done_q      <= done_d;
            brk_done_q  <= brk_done_d;
            brk_idle_q  <= brk_idle_d;
        end
    end

    assign state_o         = state_q;
    assign data_o          = data_q;
    assign fifo_rd_o       = pop;
    assign done_o          = done_q;
    assign brk_done_o      = brk_done_q;
    assign brk_idle_done_o = brk_idle_q;

    AST_POP_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n) fifo_rd_o |-> !fifo_empty); // R6
    AST_START_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_START && $past(state_q) != ST_START) |-> $past(fifo_rd_o)); // R6
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n) !baud_tick |=> $stable(state_q)); // R10
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done_q, brk_done_q, brk_idle_q})); // R12
    AST_DONE_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) done_q |-> $past(fifo_empty)); // R7
    AST_BRK_DONE_FROM_BRK: assert property (@(posedge clk) disable iff (!rst_n) brk_done_q |-> $past(state_q) == ST_BRK); // R8

endmodule

// File: rtl/txb_line_mux.sv
// Line level selector: maps the sequencer state and captured byte to the
// undelayed serial level. Assumes parity polarity is stable during a frame.
module txb_line_mux
    import txb_pkg::*;
(
    input  txb_state_e               state_i,
    input  logic [TXB_DATA_BITS-1:0] data_i,
    input  logic                     cfg_parity_odd,
    output logic                     line_o
);

    logic [3:0] bit_off;

    assign bit_off = 4'(state_i) - 4'(ST_D0);

    // Choose the level for the current bit period.
    always_comb begin
        unique case (state_i)
            ST_START, ST_BRK: line_o = 1'b0;
            ST_D0, ST_D1, ST_D2, ST_D3,
            ST_D4, ST_D5, ST_D6, ST_D7: line_o = data_i[bit_off[2:0]];
            ST_PAR:           line_o = (^data_i) ^ cfg_parity_odd;
            default:          line_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/txb_delay_line.sv
// Programmable output delay: a chain of flops that reset to the idle level,
// with a tap chosen by the delay setting (0 = no delay).
module txb_delay_line #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [DLY_W-1:0] sel,
    output logic             dout
);

    localparam int STAGES = (1 << DLY_W) - 1;

    logic [STAGES-1:0] pipe_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            // First stage samples the undelayed line.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[g] <= 1'b1;
                else        pipe_q[g] <= din;
            end
        end else begin : g_body
            // Later stages shift the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[g] <= 1'b1;
                else        pipe_q[g] <= pipe_q[g-1];
            end
        end
    end

    assign dout = (sel == '0) ? din : pipe_q[sel - DLY_W'(1)];

endmodule

// File: rtl/serial_brk_tx.sv
// Top of the break-capable serial transmitter. Connects the sequencer, the
// line selector and the output delay. Assumes baud_tick is a single-cycle
// pulse and configuration changes only while idle.
module serial_brk_tx
    import txb_pkg::*;
#(
    parameter int IDLE_W = 10,
    parameter int BRK_W  = 8,
    parameter int DLY_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              fifo_empty,
    input  logic [7:0]        fifo_rdata,
    output logic              fifo_rd,
    input  logic              cfg_parity_en,
    input  logic              cfg_parity_odd,
    input  logic              cfg_two_stop,
    input  logic [IDLE_W-1:0] cfg_idle_bits,
    input  logic              cfg_brk_en,
    input  logic [BRK_W-1:0]  cfg_brk_bits,
    input  logic [DLY_W-1:0]  cfg_txd_delay,
    output logic              txd,
    output logic [3:0]        tx_state,
    output logic              tx_done,
    output logic              brk_done,
    output logic              brk_idle_done
);

    txb_state_e               seq_state;
    logic [TXB_DATA_BITS-1:0] seq_data;
    logic                     line_raw;

    txb_sequencer #(.IDLE_W(IDLE_W), .BRK_W(BRK_W)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .baud_tick       (baud_tick),
        .fifo_empty      (fifo_empty),
        .fifo_rdata      (fifo_rdata),
        .cfg_parity_en   (cfg_parity_en),
        .cfg_two_stop    (cfg_two_stop),
        .cfg_idle_bits   (cfg_idle_bits),
        .cfg_brk_en      (cfg_brk_en),
        .cfg_brk_bits    (cfg_brk_bits),
        .state_o         (seq_state),
        .data_o          (seq_data),
        .fifo_rd_o       (fifo_rd),
        .done_o          (tx_done),
        .brk_done_o      (brk_done),
        .brk_idle_done_o (brk_idle_done)
    );

    txb_line_mux u_mux (
        .state_i        (seq_state),
        .data_i         (seq_data),
        .cfg_parity_odd (cfg_parity_odd),
        .line_o         (line_raw)
    );

    txb_delay_line #(.DLY_W(DLY_W)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (line_raw),
        .sel   (cfg_txd_delay),
        .dout  (txd)
    );

    assign tx_state = 4'(seq_state);

endmodule

// File: tb/serial_brk_tx_tb_top.sv
module serial_brk_tx_tb_top;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       fifo_empty = 1'b1;
    logic [7:0] fifo_rdata = 8'h00;
    logic       fifo_rd;
    logic       cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0, cfg_two_stop = 1'b0;
    logic [9:0] cfg_idle_bits = '0;
    logic       cfg_brk_en = 1'b0;
    logic [7:0] cfg_brk_bits = '0;
    logic [3:0] cfg_txd_delay = '0;
    logic       txd;
    logic [3:0] tx_state;
    logic       tx_done, brk_done, brk_idle_done;

    int vec_cnt = 0;
    int err_cnt = 0;
    logic [7:0] fq[$];
    int pop_req = 0, pop_done = 0, bad_pop = 0;
    int tdiv = 0;

    always #5 clk = ~clk;

    serial_brk_tx dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd),
        .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
        .cfg_two_stop(cfg_two_stop), .cfg_idle_bits(cfg_idle_bits),
        .cfg_brk_en(cfg_brk_en), .cfg_brk_bits(cfg_brk_bits),
        .cfg_txd_delay(cfg_txd_delay), .txd(txd), .tx_state(tx_state),
        .tx_done(tx_done), .brk_done(brk_done), .brk_idle_done(brk_idle_done)
    );

    // Count pops requested by the design at the clock edge.
    always @(posedge clk) begin
        if (fifo_rd) pop_req <= pop_req + 1;
        if (fifo_rd && fifo_empty) bad_pop <= bad_pop + 1;
    end

    // FIFO model and bit-rate tick, updated away from the active edge.
    always @(negedge clk) begin
        while (pop_done != pop_req) begin
            if (fq.size() > 0) fq.delete(0);
            pop_done++;
        end
        fifo_empty = (fq.size() == 0);
        fifo_rdata = (fq.size() > 0) ? fq[0] : 8'h00;
        tdiv = (tdiv == DIV - 1) ? 0 : tdiv + 1;
        baud_tick = (tdiv == DIV - 1);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec_cnt++;
        if (!ok) begin
            err_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] st);
        case (st)
            4'd10:   return "R3";
            4'd12:   return "R4";
            4'd13:   return "R8";
            4'd14:   return "R5/R9";
            default: return "R2";
        endcase
    endfunction

    task automatic run_case(input int nb, input int pmode, input bit ts, input int idle,
                            input bit be, input int bn, input int seed);
        logic [3:0] es[$];
        logic       el[$];
        int frame_len, gap_after, ns, guard, nd, nbd, nbid, d_at, bd_at, bid_at;
        int stab_err, pops0;
        bit started;
        logic [3:0] prev_st;
        cfg_parity_en  = (pmode != 0);
        cfg_parity_odd = (pmode == 2);
        cfg_two_stop   = ts;
        cfg_idle_bits  = 10'(idle);
        cfg_brk_en     = be;
        cfg_brk_bits   = 8'(bn);
        pops0 = pop_req;
        for (int k = 0; k < nb; k++) begin
            logic [7:0] b;
            b = 8'(seed * 29 + k * 113 + 7);
            fq.push_back(b);
            es.push_back(4'd1); el.push_back(1'b0);
            for (int i = 0; i < 8; i++) begin
                es.push_back(4'(2 + i)); el.push_back(b[i]);
            end
            if (pmode != 0) begin
                es.push_back(4'd10); el.push_back((^b) ^ (pmode == 2));
            end
            es.push_back(4'd11); el.push_back(1'b1);
            if (ts) begin es.push_back(4'd12); el.push_back(1'b1); end
            for (int g = 0; g < idle; g++) begin es.push_back(4'd14); el.push_back(1'b1); end
        end
        frame_len = es.size();
        gap_after = (idle == 0) ? 1 : idle;
        if (be && bn > 0) begin
            for (int i = 0; i < bn; i++) begin es.push_back(4'd13); el.push_back(1'b0); end
            for (int i = 0; i < gap_after; i++) begin es.push_back(4'd14); el.push_back(1'b1); end
        end
        ns = 0; guard = 0; nd = 0; nbd = 0; nbid = 0;
        d_at = -1; bd_at = -1; bid_at = -1; stab_err = 0; started = 0;
        prev_st = tx_state;
        forever begin
            @(negedge clk);
            guard++;
            if (guard > 5000) begin
                chk(0, "R2 case hung", guard, 0);
                break;
            end
            if (tx_done)       begin nd++;   d_at = ns;   end
            if (brk_done)      begin nbd++;  bd_at = ns;  end
            if (brk_idle_done) begin nbid++; bid_at = ns; end
            if (!baud_tick && tx_state != prev_st && prev_st != 4'd0) stab_err++;
            if (baud_tick) begin
                if (!started && tx_state != 4'd0) started = 1;
                if (started) begin
                    if (tx_state == 4'd0) break;
                    if (ns < es.size())
                        chk(tx_state == es[ns] && txd == el[ns], tag_of(es[ns]),
                            int'({tx_state, txd}), int'({es[ns], el[ns]}));
                    ns++;
                end
            end
            prev_st = tx_state;
        end
        chk(ns == es.size(), "R5 period count", ns, es.size());
        chk(nd == 1 && d_at == frame_len, "R7 done position", d_at, frame_len);
        if (be && bn > 0) begin
            chk(nbd == 1 && bd_at == frame_len + bn, "R8 break length", bd_at, frame_len + bn);
            chk(nbid == 1 && bid_at == frame_len + bn + gap_after, "R9 recovery",
                bid_at, frame_len + bn + gap_after);
        end else begin
            chk(nbd == 0 && nbid == 0, "R8 no break", nbd + nbid, 0);
        end
        chk(pop_req - pops0 == nb, "R6 pop count", pop_req - pops0, nb);
        chk(stab_err == 0, "R10 state between ticks", stab_err, 0);
        repeat (2 * DIV) @(negedge clk);
    endtask

    task automatic run_delay(input int d);
        int c, guard;
        cfg_parity_en = 0; cfg_two_stop = 0; cfg_idle_bits = '0;
        cfg_brk_en = 0; cfg_txd_delay = 4'(d);
        repeat (20) @(negedge clk);
        fq.push_back(8'hFF);
        guard = 0;
        while (tx_state != 4'd1 && guard < 200) begin @(negedge clk); guard++; end
        c = 0;
        while (txd !== 1'b0 && c < 40) begin @(negedge clk); c++; end
        chk(c == d, "R11 delay", c, d);
        repeat (80) @(negedge clk);
    endtask

    // Global watchdog: a hung run counts as a failed check.
    initial begin
        #(150000 * 10);
        err_cnt++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

    // Main stimulus: reset, sweep of frame configurations, delay sweep.
    initial begin
        int seed;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(txd == 1'b1, "R1 txd", txd, 1);
        chk(tx_state == 4'd0, "R1 state", tx_state, 0);
        chk({fifo_rd, tx_done, brk_done, brk_idle_done} == 4'b0, "R1 strobes",
            {fifo_rd, tx_done, brk_done, brk_idle_done}, 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        seed = 1;
        for (int nb = 1; nb <= 2; nb++)
            for (int pm = 0; pm < 3; pm++)
                for (int ts = 0; ts < 2; ts++)
                    for (int ii = 0; ii < 3; ii++)
                        for (int bm = 0; bm < 4; bm++) begin
                            int idle, bn;
                            bit be;
                            idle = (ii == 0) ? 0 : (ii == 1) ? 1 : 3;
                            be   = (bm != 0);
                            bn   = (bm == 1) ? 1 : (bm == 2) ? 5 : 0;
                            run_case(nb, pm, ts[0], idle, be, bn, seed);
                            seed++;
                        end
        chk(bad_pop == 0, "R6 pop on empty", bad_pop, 0);
        for (int d = 0; d < 16; d++) run_delay(d);
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    end

endmodule